// File: doc/BRIEF.md
# Weighted Time-Slice Task Scheduler

This block decides, on every clock, which of four hardware tasks may issue one instruction into a single shared pipeline. The order comes from a programmable table of sixteen 2-bit slot entries. A slot pointer steps through the table one entry per clock, so tasks interleave instruction by instruction. There is no switch instruction and nothing is saved or restored. A task that appears in more entries gets a larger share of the issue bandwidth. A table with fifteen entries for one task and one entry for a second task gives the second task a small, steady background share.

The block keeps a program counter and Z/C flags for each task. It presents the selected task's PC and flags to fetch. Each instruction carries its task tag down the pipe. At retirement, the pipe writes back the new PC and flags under that tag. A non-blocking wait test writes the state of a wait condition into the tagged task's C flag, so a task can poll for an event without stalling the pipe or its neighbours. Pointer and index registers are shared among the tasks and are not held here.

Top module: `task_sched`

## Requirements
- R1: After reset the slot table is all zeros, so every slot belongs to task 0. All program counters and flags are zero, and the slot pointer is at slot 0.
- R2: The slot pointer advances by one on every clock and wraps from 15 to 0. The issuing task is the table entry at the pointer, where entry k occupies bits [2k+1:2k] of the table word.
- R3: A table word written through `tbl_wr`/`tbl_data` is used from the next slot 0 that follows the write's clock edge. A write presented while the pointer is at slot 15 applies to the very next cycle. No pass through the table ever mixes old and new entries.
- R4: Each issue of a task advances that task's PC by one, modulo 2^12, on the following cycle. The PCs of the other tasks are not touched.
- R5: When a slot's task has its `task_en` bit low, `issue_valid` is low for that slot and the task's PC does not change.
- R6: A retirement write-back changes the PC (when `rt_pc_we` is set) and the Z/C flags (when `rt_flag_we` is set) of only the task named by `rt_task`.
- R7: When a PC write-back targets the task that issues in the same cycle, `issue_pc` shows the written PC in that cycle, and the task's next PC is the written PC plus one.
- R8: A wait test (`wc_valid`) sets the tagged task's C flag to `wc_met` on the next cycle and never suppresses issue. If a flag write-back targets the same task in the same cycle, the wait test decides C and the write-back still decides Z.
- R9: A skewed table such as 0xC0000000 (slots 0 to 14 for task 0, slot 15 for task 3) issues task 0 fifteen times and then task 3 once, in each pass.
- R10: `issue_z` and `issue_c` show the stored flags of the task selected in the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr | input | 1 | Load a new slot table word |
| tbl_data | input | 32 | New slot table; entry k at bits [2k+1:2k] |
| task_en | input | 4 | Per-task issue enable |
| rt_valid | input | 1 | Retirement write-back present |
| rt_task | input | 2 | Task tag of the retiring instruction |
| rt_pc_we | input | 1 | Retiring instruction writes the PC |
| rt_pc | input | 12 | New PC value |
| rt_flag_we | input | 1 | Retiring instruction writes Z and C |
| rt_z | input | 1 | New Z flag |
| rt_c | input | 1 | New C flag |
| wc_valid | input | 1 | Non-blocking wait test present |
| wc_task | input | 2 | Task tag of the wait test |
| wc_met | input | 1 | Wait condition is satisfied |
| issue_valid | output | 1 | This slot issues an instruction |
| issue_task | output | 2 | Task owning the current slot |
| issue_pc | output | 12 | Fetch PC of the current slot's task (forwarded) |
| issue_z | output | 1 | Z flag of the current slot's task |
| issue_c | output | 1 | C flag of the current slot's task |

## Verification
A task can issue in the same cycle that a retiring instruction rewrites its PC. In that case the fetch must take the written value, and the increment must build on it. Taking the stale PC or losing the increment are both errors. The bench produces this collision on purpose: in many cycles it tags the write-back with the task its own model expects to issue. It then compares `issue_pc` in that cycle and the PC at that task's next turn against a model that applies the write first and the increment second. A wait test and a flag write-back aimed at the same task are collided in the same way, and the check is that C follows the wait test while Z follows the write-back.

// File: rtl/tsk_pkg.sv
package tsk_pkg;

    parameter int NTASK  = 4;
    parameter int NSLOT  = 16;
    parameter int PC_W   = 12;
    parameter int TID_W  = $clog2(NTASK);
    parameter int SLOT_W = $clog2(NSLOT);
    parameter int TBL_W  = NSLOT * TID_W;

    typedef logic [TID_W-1:0]  tid_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [TBL_W-1:0]  tbl_t;

    // one retiring instruction, tagged with its task
    typedef struct packed {
        logic valid;
        tid_t tid;
        logic pc_we;
        pc_t  pc;
        logic flag_we;
        logic z;
        logic c;
    } retire_t;

    // non-blocking wait test result
    typedef struct packed {
        logic valid;
        tid_t tid;
        logic met;
    } waitchk_t;

    // architectural context of one task
    typedef struct packed {
        pc_t  pc;
        logic z;
        logic c;
    } ctx_t;

    function automatic tid_t slot_owner(tbl_t tbl, slot_t s);
        return tbl[s*TID_W +: TID_W];
    endfunction

endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import tsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tbl_wr,
    input  tbl_t  tbl_data,
    output slot_t slot_q,
    output tid_t  owner
);

    localparam slot_t LAST_SLOT = slot_t'(NSLOT - 1);

    tbl_t active_q;
    tbl_t staged_q;
    tbl_t staged_nx;

    // the latest write waits in the staging register until the wrap
    assign staged_nx = tbl_wr ? tbl_data : staged_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            active_q <= '0;
            staged_q <= '0;
        end else begin
            slot_q   <= slot_q + 1'b1;
            staged_q <= staged_nx;
            if (slot_q == LAST_SLOT)
                active_q <= staged_nx;
        end
    end

    assign owner = slot_owner(active_q, slot_q);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> slot_q == slot_t'($past(slot_q) + 1'b1)); // R2

    AST_TBL_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (slot_q != '0) |-> $stable(active_q)); // R3

endmodule

// File: rtl/task_ctx.sv
module task_ctx
    import tsk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_hit,
    input  logic pc_hit,
    input  pc_t  pc_new,
    input  logic flag_hit,
    input  logic z_new,
    input  logic c_new,
    input  logic wc_hit,
    input  logic wc_met,
    output ctx_t ctx_q,
    output pc_t  fetch_pc
);

    pc_t  pc_base;
    ctx_t ctx_nx;

    // a write-back in the fetch cycle is forwarded to fetch
    assign pc_base  = pc_hit ? pc_new : ctx_q.pc;
    assign fetch_pc = pc_base;

    always_comb begin
        ctx_nx    = ctx_q;
        ctx_nx.pc = issue_hit ? pc_t'(pc_base + 1'b1) : pc_base;
        if (flag_hit) begin
            ctx_nx.z = z_new;
            ctx_nx.c = c_new;
        end
        if (wc_hit)
            ctx_nx.c = wc_met;
    end

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= '0;
        else     ctx_q <= ctx_nx;
    end

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!issue_hit && !pc_hit) |=> ctx_q.pc == $past(ctx_q.pc)); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue_hit && !pc_hit) |=> ctx_q.pc == pc_t'($past(ctx_q.pc) + 1'b1)); // R4

    AST_FWD_THEN_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue_hit && pc_hit) |=> ctx_q.pc == pc_t'($past(pc_new) + 1'b1)); // R7

    AST_WAIT_SETS_C: assert property (@(posedge clk) disable iff (rst)
        wc_hit |=> ctx_q.c == $past(wc_met)); // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!flag_hit && !wc_hit) |=> $stable({ctx_q.z, ctx_q.c})); // R6

endmodule

// File: rtl/task_sched.sv
module task_sched
    import tsk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tbl_wr,
    input  logic [TBL_W-1:0]     tbl_data,
    input  logic [NTASK-1:0]     task_en,
    input  logic                 rt_valid,
    input  logic [TID_W-1:0]     rt_task,
    input  logic                 rt_pc_we,
    input  logic [PC_W-1:0]      rt_pc,
    input  logic                 rt_flag_we,
    input  logic                 rt_z,
    input  logic                 rt_c,
    input  logic                 wc_valid,
    input  logic [TID_W-1:0]     wc_task,
    input  logic                 wc_met,
    output logic                 issue_valid,
    output logic [TID_W-1:0]     issue_task,
    output logic [PC_W-1:0]      issue_pc,
    output logic                 issue_z,
    output logic                 issue_c
);

    slot_t    slot_q;
    tid_t     owner;
    retire_t  rt;
    waitchk_t wc;

    ctx_t             ctx   [NTASK];
    pc_t              fpc   [NTASK];
    logic [NTASK-1:0] hit_vec;

    assign rt = '{valid: rt_valid, tid: rt_task, pc_we: rt_pc_we, pc: rt_pc,
                  flag_we: rt_flag_we, z: rt_z, c: rt_c};
    assign wc = '{valid: wc_valid, tid: wc_task, met: wc_met};

    slot_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .tbl_wr   (tbl_wr),
        .tbl_data (tbl_data),
        .slot_q   (slot_q),
        .owner    (owner)
    );

    for (genvar t = 0; t < NTASK; t++) begin : g_task
        logic mine_issue;
        logic mine_pc;
        logic mine_flag;
        logic mine_wc;

        assign mine_issue = (owner == tid_t'(t)) && task_en[t];
        assign mine_pc    = rt.valid && rt.pc_we && (rt.tid == tid_t'(t));
        assign mine_flag  = rt.valid && rt.flag_we && (rt.tid == tid_t'(t));
        assign mine_wc    = wc.valid && (wc.tid == tid_t'(t));
        assign hit_vec[t] = mine_issue;

        task_ctx u_ctx (
            .clk       (clk),
            .rst       (rst),
            .issue_hit (mine_issue),
            .pc_hit    (mine_pc),
            .pc_new    (rt.pc),
            .flag_hit  (mine_flag),
            .z_new     (rt.z),
            .c_new     (rt.c),
            .wc_hit    (mine_wc),
            .wc_met    (wc.met),
            .ctx_q     (ctx[t]),
            .fetch_pc  (fpc[t])
        );
    end

    assign issue_task  = owner;
    assign issue_valid = task_en[owner];
    assign issue_pc    = fpc[owner];
    assign issue_z     = ctx[owner].z;
    assign issue_c     = ctx[owner].c;

    AST_ONE_ISSUER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2

    AST_BUBBLE_NO_ISSUER: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> hit_vec == '0); // R5

endmodule

// File: tb/sim_task_sched.sv
`timescale 1ns/1ps
module sim_task_sched;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_wr;
    logic [31:0] tbl_data;
    logic [3:0]  task_en;
    logic        rt_valid;
    logic [1:0]  rt_task;
    logic        rt_pc_we;
    logic [11:0] rt_pc;
    logic        rt_flag_we;
    logic        rt_z;
    logic        rt_c;
    logic        wc_valid;
    logic [1:0]  wc_task;
    logic        wc_met;
    logic        issue_valid;
    logic [1:0]  issue_task;
    logic [11:0] issue_pc;
    logic        issue_z;
    logic        issue_c;

    always #2 clk = ~clk;

    task_sched u0 (.*);

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;
    string req = "R1";

    // behavioural reference state
    int m_tbl [16];
    int m_pend[16];
    int m_slot;
    int m_pc [4];
    int m_z  [4];
    int m_c  [4];

    task automatic chk(string what, string rq, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < 16; k++) begin m_tbl[k] = 0; m_pend[k] = 0; end
        m_slot = 0;
        for (int t = 0; t < 4; t++) begin m_pc[t] = 0; m_z[t] = 0; m_c[t] = 0; end
    endfunction

    // compare in mid-cycle, then advance the model at the edge
    task automatic cyc();
        int tk;
        int epc;
        bit iss;
        #1;
        tk  = m_tbl[m_slot];
        iss = task_en[tk];
        epc = (rt_valid && rt_pc_we && rt_task == tk) ? int'(rt_pc) : m_pc[tk];
        chk("issue_task", req, int'(issue_task), tk);
        chk("issue_valid", iss ? req : "R5", int'(issue_valid), int'(iss));
        chk("issue_pc", req, int'(issue_pc), epc);
        chk("issue_z", "R10", int'(issue_z), m_z[tk]);
        chk("issue_c", "R10", int'(issue_c), m_c[tk]);
        @(posedge clk);
        if (tbl_wr)
            for (int k = 0; k < 16; k++) m_pend[k] = int'((tbl_data >> (2*k)) & 32'h3);
        if (m_slot == 15)
            for (int k = 0; k < 16; k++) m_tbl[k] = m_pend[k];
        m_slot = (m_slot + 1) % 16;
        for (int t = 0; t < 4; t++) begin
            int b;
            b = (rt_valid && rt_pc_we && rt_task == t) ? int'(rt_pc) : m_pc[t];
            if (iss && tk == t) b = (b + 1) % 4096;
            m_pc[t] = b;
            if (rt_valid && rt_flag_we && rt_task == t) begin m_z[t] = rt_z; m_c[t] = rt_c; end
            if (wc_valid && wc_task == t) m_c[t] = wc_met;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        tbl_wr = 0; rt_valid = 0; rt_pc_we = 0; rt_flag_we = 0; wc_valid = 0;
    endtask

    task automatic rand_traffic(bit aim);
        rt_valid   = ($urandom % 2) == 0;
        rt_pc_we   = ($urandom % 2) == 0;
        rt_flag_we = ($urandom % 2) == 0;
        rt_task    = aim ? 2'(m_tbl[m_slot]) : 2'($urandom % 4);
        rt_pc      = 12'($urandom);
        rt_z       = 1'($urandom);
        rt_c       = 1'($urandom);
        wc_valid   = ($urandom % 3) == 0;
        wc_task    = ($urandom % 2) ? rt_task : 2'($urandom % 4);
        wc_met     = 1'($urandom);
    endtask

    initial begin
        rst = 1; task_en = 4'hF; tbl_data = '0; rt_task = 0; rt_pc = 0;
        rt_z = 0; rt_c = 0; wc_task = 0; wc_met = 0;
        idle_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state at the ports
        chk("reset task", "R1", int'(issue_task), 0);
        chk("reset valid", "R1", int'(issue_valid), 1);
        chk("reset pc", "R1", int'(issue_pc), 0);
        chk("reset flags", "R1", int'({issue_z, issue_c}), 0);
        @(negedge clk);
        m_slot = 0;
        // the negedge wait above let one edge pass; resync model to it
        m_slot = 1; m_pc[0] = 1;

        // R2/R4: default table, task 0 at full rate
        req = "R2";
        repeat (20) cyc();

        // R3: equal share table written mid-pass
        req = "R3";
        tbl_data = 32'hE4E4_E4E4; tbl_wr = 1;
        cyc();
        tbl_wr = 0;
        repeat (40) cyc();

        // R5: task 2 disabled
        req = "R4";
        task_en = 4'b1011;
        repeat (24) cyc();
        task_en = 4'hF;

        // R6/R7/R8: tagged write-backs, aimed collisions, wait tests
        req = "R7";
        for (int i = 0; i < 300; i++) begin
            rand_traffic(i % 3 == 0);
            cyc();
        end
        idle_inputs();

        // R9 and R3: skewed table written while the pointer is at slot 15
        req = "R3";
        while (m_slot != 15) cyc();
        tbl_data = 32'hC000_0000; tbl_wr = 1;
        cyc();
        tbl_wr = 0;
        req = "R9";
        for (int i = 0; i < 64; i++) begin
            rand_traffic(1'b0);
            cyc();
        end
        idle_inputs();
        repeat (32) cyc();

        // R6: write-back to an idle task observed on its next turn
        req = "R6";
        tbl_data = 32'hE4E4_E4E4; tbl_wr = 1;
        cyc();
        tbl_wr = 0;
        for (int i = 0; i < 40; i++) begin
            rand_traffic(1'b0);
            cyc();
        end
        idle_inputs();
        repeat (8) cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule